// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block stands in for the digital output side of a serial successive-approximation converter. A host-side design under test talks to it exactly as it would to a real converter. The host lowers an active-low select, toggles a data clock, and reads a single serial data line. The block supplies the 16-bit two's complement result from a parallel input. Analog behaviour and internal propagation delays are not modelled.

Each frame begins when select falls. For a fixed number of falling data-clock edges the block is sampling and leaves the data line undriven. It then drives one low null bit. The word follows most significant bit first. The word then repeats least significant bit first, starting from bit 1. After that the line is released and further clocks are ignored. Raising select ends the frame at any point, which allows short-cycled reads. The block also reports a phase code and two power-down levels. Full power-down follows select. Analog-only power-down begins once the conversion has finished while select stays low.

Top module: `adc_serial_seq`

## Requirements
- R1: While `cs_n` is high, `sdata` is high-impedance, `phase` reads 0 (idle), and both `pd_full` and `pd_analog` are 1.
- R2: After `cs_n` falls, `sdata` stays high-impedance through the first SAMPLE_EDGES-1 falling `dclk` edges, with `phase` = 1. On falling edge SAMPLE_EDGES (5 by default) `sdata` is driven 0 for exactly one clock, with `phase` = 2.
- R3: On the next DATA_W falling edges, `sdata` carries the captured word from bit DATA_W-1 down to bit 0, one bit per edge, with `phase` = 3. Each bit is valid immediately after its edge.
- R4: On the following DATA_W-1 falling edges, `sdata` carries bits 1 up to DATA_W-1, one per edge, with `phase` = 4.
- R5: On the falling edge after bit DATA_W-1 has been repeated, `sdata` returns to high-impedance and `phase` becomes 5 (done). Any further `dclk` edges while `cs_n` stays low leave both unchanged.
- R6: `sample` is taken on falling edge SAMPLE_EDGES. Later changes to `sample` within the same frame do not alter the bits that are shifted out.
- R7: A rising `cs_n` ends the frame at once, without a clock: `sdata` goes high-impedance and `phase` goes to 0. The next falling `cs_n` starts a new frame in the sampling phase.
- R8: With `cs_n` low, `pd_full` is 0. `pd_analog` is 0 during the sampling, null and MSB-first phases, and 1 during the LSB-first and done phases.
- R9: The data word is passed through without alteration as two's complement. The extreme codes 16'h7FFF, 16'h8000, 16'hFFFF and 16'h0000 serialize bit-exact in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Data clock from the host; all frame state advances on its falling edge |
| cs_n | input | 1 | Active-low select; high holds the frame in reset |
| sample | input | DATA_W | Parallel two's complement word to be shifted out |
| sdata | output | 1 | Serial data line, high-impedance when not driving |
| phase | output | 3 | Frame phase: 0 idle, 1 sampling, 2 null, 3 MSB-first, 4 LSB-first, 5 done |
| pd_full | output | 1 | Whole device powered down |
| pd_analog | output | 1 | Analog section powered down |

## Verification
The bench builds the block with DATA_W = 16 and SAMPLE_EDGES = 5, which makes a complete frame 37 falling edges long. That length lets every phase boundary be reached in a single frame: the null bit, the turn from bit 0 back to bit 1, and the release after the repeated top bit. Full frames run with the extreme two's complement codes and a mixed pattern. Separate frames cover a word change after capture, a frame kept running far past done, and a frame cut short by select mid-word followed by a fresh frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMPLE = 3'd1,
        PH_NULL   = 3'd2,
        PH_MSB    = 3'd3,
        PH_LSB    = 3'd4,
        PH_DONE   = 3'd5
    } phase_e;

    function automatic logic is_drive_phase(phase_e ph);
        return (ph == PH_NULL) || (ph == PH_MSB) || (ph == PH_LSB);
    endfunction

    function automatic logic is_post_conv(phase_e ph);
        return (ph == PH_LSB) || (ph == PH_DONE);
    endfunction

endpackage

// File: rtl/adc_seq_frame.sv
module adc_seq_frame
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SAMPLE_EDGES = 5
) (
    input  logic                      dclk,
    input  logic                      cs_n,
    output phase_e                    phase_o,
    output logic [$clog2(DATA_W)-1:0] idx_o,
    output logic                      capture_o
);

    localparam int CW = $clog2(SAMPLE_EDGES + 1);
    localparam int IW = $clog2(DATA_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(SAMPLE_EDGES - 1);
    localparam logic [IW-1:0] IDX_TOP  = IW'(DATA_W - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
    } frame_t;

    frame_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_SAMPLE: begin
                if (st_q.cnt == CNT_LAST) begin
                    st_d.ph  = PH_NULL;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_NULL: begin
                st_d.ph  = PH_MSB;
                st_d.idx = IDX_TOP;
            end
            PH_MSB: begin
                if (st_q.idx == '0) begin
                    st_d.ph  = PH_LSB;
                    st_d.idx = IW'(1);
                end else begin
                    st_d.idx = st_q.idx - 1'b1;
                end
            end
            PH_LSB: begin
                if (st_q.idx == IDX_TOP) begin
                    st_d.ph = PH_DONE;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(negedge dclk or posedge cs_n) begin
        if (cs_n) begin
            st_q <= '{ph: PH_SAMPLE, cnt: '0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o   = st_q.ph;
    assign idx_o     = st_q.idx;
    assign capture_o = (st_q.ph == PH_SAMPLE) && (st_q.cnt == CNT_LAST);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      dclk,
    input  logic                      cs_n,
    input  logic                      capture_i,
    input  logic [DATA_W-1:0]         sample_i,
    input  phase_e                    phase_i,
    input  logic [$clog2(DATA_W)-1:0] idx_i,
    output logic                      drive_en_o,
    output logic                      bit_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (capture_i) begin
            hd_d.word = sample_i;
        end
    end

    always_ff @(negedge dclk or posedge cs_n) begin
        if (cs_n) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign drive_en_o = !cs_n && is_drive_phase(phase_i);
    assign bit_o      = (phase_i == PH_NULL) ? 1'b0 : hd_q.word[idx_i];

endmodule

// File: rtl/adc_seq_power.sv
module adc_seq_power
    import adc_seq_pkg::*;
(
    input  logic   cs_n,
    input  phase_e phase_i,
    output logic   pd_full_o,
    output logic   pd_analog_o
);

    assign pd_full_o   = cs_n;
    assign pd_analog_o = cs_n || is_post_conv(phase_i);

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int SAMPLE_EDGES = 5
) (
    input  logic              dclk,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] sample,
    output logic              sdata,
    output logic [2:0]        phase,
    output logic              pd_full,
    output logic              pd_analog
);

    localparam int IW = $clog2(DATA_W);

    phase_e          frame_ph;
    logic [IW-1:0]   frame_idx;
    logic            capture;
    logic            drive_en;
    logic            out_bit;
    phase_e          status;

    adc_seq_frame #(
        .DATA_W       (DATA_W),
        .SAMPLE_EDGES (SAMPLE_EDGES)
    ) u_frame (
        .dclk      (dclk),
        .cs_n      (cs_n),
        .phase_o   (frame_ph),
        .idx_o     (frame_idx),
        .capture_o (capture)
    );

    adc_seq_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .dclk       (dclk),
        .cs_n       (cs_n),
        .capture_i  (capture),
        .sample_i   (sample),
        .phase_i    (frame_ph),
        .idx_i      (frame_idx),
        .drive_en_o (drive_en),
        .bit_o      (out_bit)
    );

    adc_seq_power u_power (
        .cs_n        (cs_n),
        .phase_i     (frame_ph),
        .pd_full_o   (pd_full),
        .pd_analog_o (pd_analog)
    );

    assign status = cs_n ? PH_IDLE : frame_ph;
    assign phase  = status;
    assign sdata  = drive_en ? out_bit : 1'bz;

endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk (
    input logic       dclk,
    input logic       cs_n,
    input logic       drive_en,
    input logic [2:0] phase,
    input logic       pd_full,
    input logic       pd_analog
);

    // R1: select high never lets the line be driven
    a_r1_quiet_when_deselected: assert property (@(negedge dclk)
        cs_n |-> (!drive_en && pd_full && pd_analog));

    // R3: the null bit is always followed by the MSB-first phase
    a_r3_null_then_msb: assert property (@(negedge dclk) disable iff (cs_n)
        (phase == 3'd2) |=> (phase == 3'd3));

    // R4: LSB-first phase only moves on to itself or to done
    a_r4_lsb_exit: assert property (@(negedge dclk) disable iff (cs_n)
        (phase == 3'd4) |=> ((phase == 3'd4) || (phase == 3'd5)));

    // R5: done is sticky and releases the line
    a_r5_done_sticky: assert property (@(negedge dclk) disable iff (cs_n)
        (phase == 3'd5) |=> ((phase == 3'd5) && !drive_en));

    // R8: analog section is powered while converting
    a_r8_analog_on_in_conv: assert property (@(negedge dclk) disable iff (cs_n)
        ((phase == 3'd1) || (phase == 3'd2) || (phase == 3'd3)) |-> (!pd_analog && !pd_full));

    // R9: phase code stays within its legal set
    a_r9_phase_legal: assert property (@(negedge dclk) disable iff (cs_n)
        (phase != 3'd0) && (phase <= 3'd5));

endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
    .dclk      (dclk),
    .cs_n      (cs_n),
    .drive_en  (drive_en),
    .phase     (phase),
    .pd_full   (pd_full),
    .pd_analog (pd_analog)
);

// File: tb/test_adc_serial_seq.sv
module test_adc_serial_seq;

    localparam int CLK_PERIOD = 20;
    localparam int DW  = 16;
    localparam int SE  = 5;
    localparam int FULL = SE + 2 * DW;

    typedef struct {
        logic       sd;
        logic [2:0] ph;
        logic       pda;
        string      req;
        int         k;
    } exp_t;

    logic          dclk = 1'b1;
    logic          cs_n = 1'b1;
    logic [DW-1:0] sample = '0;
    logic          sdata;
    logic [2:0]    phase;
    logic          pd_full;
    logic          pd_analog;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    exp_t sb_q[$];

    adc_serial_seq #(.DATA_W(DW), .SAMPLE_EDGES(SE)) i_adc_serial_seq (
        .dclk      (dclk),
        .cs_n      (cs_n),
        .sample    (sample),
        .sdata     (sdata),
        .phase     (phase),
        .pd_full   (pd_full),
        .pd_analog (pd_analog)
    );

    always #(CLK_PERIOD / 2) dclk = ~dclk;

    function automatic exp_t expect_at(int k, logic [DW-1:0] w);
        exp_t e;
        e.k = k;
        if (k < SE) begin
            e.sd = 1'bz; e.ph = 3'd1; e.pda = 1'b0; e.req = "R2";
        end else if (k == SE) begin
            e.sd = 1'b0; e.ph = 3'd2; e.pda = 1'b0; e.req = "R2";
        end else if (k <= SE + DW) begin
            e.sd = w[DW - 1 - (k - SE - 1)]; e.ph = 3'd3; e.pda = 1'b0; e.req = "R3";
        end else if (k < FULL) begin
            e.sd = w[k - SE - DW]; e.ph = 3'd4; e.pda = 1'b1; e.req = "R4";
        end else begin
            e.sd = 1'bz; e.ph = 3'd5; e.pda = 1'b1; e.req = "R5";
        end
        return e;
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(string req);
        check(req, "sdata idle", {15'd0, sdata}, {15'd0, 1'bz});
        check(req, "phase idle", {13'd0, phase}, 16'd0);
        check(req, "pd_full idle", {15'd0, pd_full}, 16'd1);
        check(req, "pd_analog idle", {15'd0, pd_analog}, 16'd1);
    endtask

    // driver: runs one frame, pushes expected values per falling edge
    task automatic run_frame(logic [DW-1:0] w, int nedges, int alt_at, logic [DW-1:0] alt_w);
        @(posedge dclk);
        sample = w;
        cs_n   = 1'b0;
        #1;
        check("R2", "phase at select", {13'd0, phase}, 16'd1);
        check("R2", "sdata at select", {15'd0, sdata}, {15'd0, 1'bz});
        check("R8", "pd_full at select", {15'd0, pd_full}, 16'd0);
        for (int k = 1; k <= nedges; k++) begin
            sb_q.push_back(expect_at(k, w));
            @(negedge dclk);
            if (k == alt_at) begin
                #1;
                sample = alt_w;   // R6: must not reach the line
            end
        end
        @(posedge dclk);
        cs_n = 1'b1;
        #1;
        check_idle("R7");
        @(negedge dclk);
        #(CLK_PERIOD / 4);
        check_idle("R1");
    endtask

    // monitor: compares outputs a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge dclk);
            #(CLK_PERIOD / 4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.req, $sformatf("sdata edge %0d", e.k), {15'd0, sdata}, {15'd0, e.sd});
                check("R9", $sformatf("phase edge %0d", e.k), {13'd0, phase}, {13'd0, e.ph});
                check("R8", $sformatf("pd_analog edge %0d", e.k), {15'd0, pd_analog}, {15'd0, e.pda});
                check("R8", $sformatf("pd_full edge %0d", e.k), {15'd0, pd_full}, 16'd0);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #1;
        check_idle("R1");
        // R9: extreme two's complement codes, full frames
        run_frame(16'h7FFF, FULL, 0, '0);
        run_frame(16'h8000, FULL, 0, '0);
        run_frame(16'hFFFF, FULL, 0, '0);
        run_frame(16'h0000, FULL, 0, '0);
        // R3 R4: mixed pattern
        run_frame(16'hA5C3, FULL, 0, '0);
        // R6: word changed right after capture and again mid-word
        run_frame(16'h3C96, FULL, SE, 16'hC369);
        run_frame(16'h1234, FULL, SE + 8, 16'hEDCB);
        // R5: clocks long past done
        run_frame(16'h5A0F, FULL + 9, 0, '0);
        // R7: short cycle mid-word, then a fresh frame
        run_frame(16'hBEEF, SE + 6, 0, '0);
        run_frame(16'h0F1E, FULL, 0, '0);
        // R2: cut inside the sampling window
        run_frame(16'h4444, SE - 2, 0, '0);
        run_frame(16'h6D2B, FULL, 0, '0);
        repeat (2) @(negedge dclk);
        finish_run();
    end

endmodule